// File: doc/BRIEF.md
# Banished-Line Readmission Counter Table

This block keeps one small saturating counter per cache line that has been banished from the private L1 caches. It decides when such a line may be cached in an L1 again. A banished line leaves that state only after a quiet spell. Each write the line takes while banished pushes its readmission further away. A shared decay timer with a programmable period pulls every counter back toward zero. When a counter has reached zero, the next read of the line is granted: the line may be refilled into the requester's L1 and stops being banished.

Three event streams arrive, each with a line index: broadcast invalidations, writes, and reads. The period input sets how often the counters decay. A period of zero means banished lines are readmitted on their next read. The decay-off input freezes decay, so lines stay banished for good. Every read receives a registered grant/deny answer one cycle later.

Top module: `readmit_table`

## Requirements
- R1: After reset no line is banished, every counter is 0, `rd_resp_vld_o` and `rd_grant_o` are 0, and a read of any line is granted.
- R2: An invalidation of a line marks it banished and loads its counter with 2. An invalidation outranks a write, a decay step or a read of the same line in the same cycle, and a read in that cycle gets a deny.
- R3: A write to a banished line adds 1 to its counter, saturating at 3. A write to a line that is not banished changes nothing.
- R4: With `decay_off_i` = 0 and period P ≥ 1, the timer counts from 0 and raises one decay step every P cycles, with the first step on the P-th enabled cycle. Each step lowers every banished counter by 1, stopping at 0.
- R5: When a write and a decay step reach the same banished line in the same cycle, they cancel and the counter keeps its value.
- R6: A read is answered on the next cycle with `rd_resp_vld_o` = 1. `rd_grant_o` = 1 exactly when the line is not banished or its counter is 0, judged on the state before that cycle's updates. A grant to a banished line clears its banished flag.
- R7: With `decay_off_i` = 0 and period 0, a read of a banished line is granted whatever its counter holds.
- R8: With `decay_off_i` = 1, no decay step occurs, the timer is held at 0 and period 0 has no special effect. A freshly invalidated line is then denied on every read.
- R9: A readmitted line can be invalidated again. This reloads its counter with 2 and banishes it once more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_i | input | PER_W | Decay period in cycles; 0 selects immediate readmission |
| decay_off_i | input | 1 | Freezes decay; lines stay banished |
| inval_vld_i | input | 1 | Broadcast invalidation event |
| inval_idx_i | input | IDX_W | Line index of the invalidation |
| wr_vld_i | input | 1 | Write event |
| wr_idx_i | input | IDX_W | Line index of the write |
| rd_vld_i | input | 1 | Read request |
| rd_idx_i | input | IDX_W | Line index of the read |
| rd_resp_vld_o | output | 1 | Response to the read of the previous cycle |
| rd_grant_o | output | 1 | 1: the line may be refilled into L1 |

## Verification
Some behaviours are checked by assertions on every cycle and for every line. These are the load value after an invalidation, the rule that a counter never falls without a decay step and never moves outside banishment, the clearing of the flag on a grant, and the absence of decay steps while decay is off. The exact decay timing and the count at which a read is first granted, which depend on the period and on how many writes came before, can only be shown by the bench's sweeps. Those sweeps cover periods 1 to 4 and zero to three writes. The cancellation of a write against a decay step is likewise shown by the bench, through the cycle in which the first grant arrives.

// File: rtl/readmit_pkg.sv
package readmit_pkg;
  localparam int CNT_W = 2;
  localparam logic [CNT_W-1:0] CNT_LOAD = 2'd2;
  localparam logic [CNT_W-1:0] CNT_MAX  = 2'd3;

  // next counter value for one banished entry
  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] cur,
                                                input logic inc, input logic dec);
    logic [CNT_W-1:0] nxt;
    nxt = cur;
    if (inc && !dec) begin
      if (cur != CNT_MAX) nxt = cur + 2'd1;
    end else if (dec && !inc) begin
      if (cur != '0) nxt = cur - 2'd1;
    end
    return nxt;
  endfunction

  // grant rule for a read, judged on pre-update state
  function automatic logic may_refill(input logic banished, input logic [CNT_W-1:0] cnt,
                                      input logic immediate);
    return !banished || (cnt == '0) || immediate;
  endfunction
endpackage

// File: rtl/readmit_timer.sv
module readmit_timer #(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] period_i,
  input  logic             decay_off_i,
  output logic             tick_o,
  output logic             immediate_o
);
  logic [PER_W-1:0] tcnt_q;
  logic             run_w;

  assign run_w       = !decay_off_i && (period_i != '0);
  assign immediate_o = !decay_off_i && (period_i == '0);
  assign tick_o      = run_w && (tcnt_q >= period_i - PER_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)      tcnt_q <= '0;
    else if (!run_w) tcnt_q <= '0;
    else if (tick_o) tcnt_q <= '0;
    else             tcnt_q <= tcnt_q + PER_W'(1);
  end
endmodule

// File: rtl/readmit_entry.sv
module readmit_entry
  import readmit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             inc_i,
  input  logic             dec_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ban_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ban_o <= 1'b0;
      cnt_o <= '0;
    end else if (load_i) begin
      ban_o <= 1'b1;
      cnt_o <= CNT_LOAD;
    end else if (clr_i) begin
      ban_o <= 1'b0;
    end else if (ban_o) begin
      cnt_o <= cnt_step(cnt_o, inc_i, dec_i);
    end
  end
endmodule

// File: rtl/readmit_table.sv
module readmit_table
  import readmit_pkg::*;
#(
  parameter int LINES = 16,
  parameter int PER_W = 8,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] period_i,
  input  logic             decay_off_i,
  input  logic             inval_vld_i,
  input  logic [IDX_W-1:0] inval_idx_i,
  input  logic             wr_vld_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             rd_vld_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_resp_vld_o,
  output logic             rd_grant_o
);
  // named internal events, also observed by the bound checker
  logic                   tick_w;
  logic                   immediate_w;
  logic                   grant_w;
  logic [LINES-1:0]       load_vec;
  logic [LINES-1:0]       inc_vec;
  logic [LINES-1:0]       clr_vec;
  logic [LINES-1:0]       ban_vec;
  logic [CNT_W-1:0]       cnt_arr [LINES];
  logic [LINES*CNT_W-1:0] cnt_flat;
  logic                   rd_hit_inval;

  readmit_timer #(.PER_W(PER_W)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .period_i    (period_i),
    .decay_off_i (decay_off_i),
    .tick_o      (tick_w),
    .immediate_o (immediate_w)
  );

  assign rd_hit_inval = inval_vld_i && (inval_idx_i == rd_idx_i);
  assign grant_w = rd_vld_i && !rd_hit_inval &&
                   may_refill(ban_vec[rd_idx_i], cnt_arr[rd_idx_i], immediate_w);

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign load_vec[i] = inval_vld_i && (inval_idx_i == IDX_W'(i));
    assign inc_vec[i]  = wr_vld_i && (wr_idx_i == IDX_W'(i));
    assign clr_vec[i]  = grant_w && (rd_idx_i == IDX_W'(i));
    assign cnt_flat[i*CNT_W +: CNT_W] = cnt_arr[i];

    readmit_entry u_entry (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load_vec[i]),
      .inc_i  (inc_vec[i]),
      .dec_i  (tick_w),
      .clr_i  (clr_vec[i]),
      .cnt_o  (cnt_arr[i]),
      .ban_o  (ban_vec[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_resp_vld_o <= 1'b0;
      rd_grant_o    <= 1'b0;
    end else begin
      rd_resp_vld_o <= rd_vld_i;
      rd_grant_o    <= grant_w;
    end
  end
endmodule

// File: rtl/readmit_checker.sv
module readmit_checker #(
  parameter int LINES = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 decay_off_i,
  input logic                 tick_w,
  input logic [LINES-1:0]     load_vec,
  input logic [LINES-1:0]     inc_vec,
  input logic [LINES-1:0]     clr_vec,
  input logic [LINES-1:0]     ban_vec,
  input logic [LINES*2-1:0]   cnt_flat,
  input logic                 rd_resp_vld_o,
  input logic                 rd_grant_o
);
  assert_grant_has_resp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_grant_o |-> rd_resp_vld_o);

  assert_one_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_vec));

  assert_frozen_decay_R8: assert property (@(posedge clk) disable iff (!rst_n)
    decay_off_i |-> !tick_w);

  for (genvar i = 0; i < LINES; i++) begin : g_chk
    assert_load_two_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load_vec[i] |=> (ban_vec[i] && cnt_flat[i*2 +: 2] == 2'd2));

    assert_no_drop_without_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ban_vec[i] && !load_vec[i] && !tick_w) |=>
        (cnt_flat[i*2 +: 2] >= $past(cnt_flat[i*2 +: 2])));

    assert_no_rise_without_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_vec[i] && !inc_vec[i]) |=>
        (cnt_flat[i*2 +: 2] <= $past(cnt_flat[i*2 +: 2])));

    assert_idle_line_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ban_vec[i] && !load_vec[i]) |=> $stable(cnt_flat[i*2 +: 2]));

    assert_grant_unbans_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[i] && !load_vec[i]) |=> !ban_vec[i]);
  end
endmodule

bind readmit_table readmit_checker #(.LINES(LINES)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .decay_off_i   (decay_off_i),
  .tick_w        (tick_w),
  .load_vec      (load_vec),
  .inc_vec       (inc_vec),
  .clr_vec       (clr_vec),
  .ban_vec       (ban_vec),
  .cnt_flat      (cnt_flat),
  .rd_resp_vld_o (rd_resp_vld_o),
  .rd_grant_o    (rd_grant_o)
);

// File: tb/readmit_table_bench.sv
module readmit_table_bench;
  localparam int LINES = 16;
  localparam int PER_W = 8;
  localparam int IDX_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [PER_W-1:0] period_i = '0;
  logic             decay_off_i = 1'b1;
  logic             inval_vld_i = 1'b0;
  logic [IDX_W-1:0] inval_idx_i = '0;
  logic             wr_vld_i = 1'b0;
  logic [IDX_W-1:0] wr_idx_i = '0;
  logic             rd_vld_i = 1'b0;
  logic [IDX_W-1:0] rd_idx_i = '0;
  logic             rd_resp_vld_o;
  logic             rd_grant_o;

  int  n_run = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  readmit_table #(.LINES(LINES), .PER_W(PER_W)) u_readmit_table (
    .clk(clk), .rst_n(rst_n), .period_i(period_i), .decay_off_i(decay_off_i),
    .inval_vld_i(inval_vld_i), .inval_idx_i(inval_idx_i),
    .wr_vld_i(wr_vld_i), .wr_idx_i(wr_idx_i),
    .rd_vld_i(rd_vld_i), .rd_idx_i(rd_idx_i),
    .rd_resp_vld_o(rd_resp_vld_o), .rd_grant_o(rd_grant_o)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic pulse_inval(input int l);
    @(negedge clk); inval_vld_i = 1'b1; inval_idx_i = IDX_W'(l);
    @(negedge clk); inval_vld_i = 1'b0;
  endtask

  task automatic pulse_write(input int l);
    @(negedge clk); wr_vld_i = 1'b1; wr_idx_i = IDX_W'(l);
    @(negedge clk); wr_vld_i = 1'b0;
  endtask

  // single read with current control settings; response checked next cycle
  task automatic read_check(input int l, input logic exp, input string tag);
    @(negedge clk); rd_vld_i = 1'b1; rd_idx_i = IDX_W'(l);
    @(negedge clk); rd_vld_i = 1'b0;
    check(rd_resp_vld_o, 1'b1, {tag, " resp valid"});
    check(rd_grant_o, exp, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(rd_resp_vld_o, 1'b0, "R1 resp idle after reset");
    check(rd_grant_o, 1'b0, "R1 grant low after reset");
    read_check(3, 1'b1, "R1 read after reset granted");

    // R3 write to a line that is not banished is ignored
    pulse_write(9); pulse_write(9); pulse_write(9);
    read_check(9, 1'b1, "R3 write on clean line ignored");

    // R2 invalidation beats same-cycle read
    period_i = 8'd1; decay_off_i = 1'b1;
    @(negedge clk); inval_vld_i = 1'b1; inval_idx_i = 4'd8; rd_vld_i = 1'b1; rd_idx_i = 4'd8;
    @(negedge clk); inval_vld_i = 1'b0; rd_vld_i = 1'b0;
    check(rd_grant_o, 1'b0, "R2 same-cycle invalidate denies read");
    read_check(8, 1'b0, "R2 line banished after invalidate");

    // R8 decay off keeps a line banished
    pulse_inval(7);
    repeat (40) @(negedge clk);
    read_check(7, 1'b0, "R8 no decay while off");
    period_i = 8'd0;
    read_check(7, 1'b0, "R8 period zero ignored while off");

    // R7 period zero readmits immediately
    decay_off_i = 1'b0;
    pulse_inval(6);
    read_check(6, 1'b1, "R7 immediate readmission");
    period_i = 8'd5; decay_off_i = 1'b1;
    read_check(6, 1'b1, "R6 granted line no longer banished");

    // R9 re-invalidation after readmission
    period_i = 8'd1;
    pulse_inval(6);
    read_check(6, 1'b0, "R9 reinvalidated line denied");

    // R5 write and decay cancel: counter stays 2, first grant at third read
    pulse_inval(5);
    @(negedge clk); decay_off_i = 1'b0; wr_vld_i = 1'b1; wr_idx_i = 4'd5;
    repeat (4) @(negedge clk);
    @(negedge clk); wr_vld_i = 1'b0; decay_off_i = 1'b1;
    @(negedge clk); decay_off_i = 1'b0; rd_vld_i = 1'b1; rd_idx_i = 4'd5;
    @(negedge clk); check(rd_grant_o, 1'b0, "R5 read 1 after cancel");
    @(negedge clk); check(rd_grant_o, 1'b0, "R5 read 2 after cancel");
    @(negedge clk); check(rd_grant_o, 1'b1, "R5 read 3 after cancel");
    rd_vld_i = 1'b0; decay_off_i = 1'b1;

    // R3 R4 R6 sweep: period P, w writes, line k-1 read at k-th enabled cycle
    for (int p = 1; p <= 4; p++) begin
      for (int w = 0; w <= 3; w++) begin
        int c;
        c = (2 + w > 3) ? 3 : 2 + w;
        period_i = PER_W'(p); decay_off_i = 1'b1;
        for (int l = 0; l < LINES; l++) pulse_inval(l);
        for (int r = 0; r < w; r++)
          for (int l = 0; l < LINES; l++) pulse_write(l);
        for (int k = 1; k <= LINES; k++) begin
          @(negedge clk);
          if (k > 1) check(rd_grant_o, ((k - 2) / p) >= c,
                           $sformatf("R4 sweep P=%0d writes=%0d read %0d", p, w, k - 1));
          decay_off_i = 1'b0; rd_vld_i = 1'b1; rd_idx_i = IDX_W'(k - 1);
        end
        @(negedge clk);
        check(rd_grant_o, ((LINES - 1) / p) >= c,
              $sformatf("R3 sweep P=%0d writes=%0d read %0d", p, w, LINES));
        rd_vld_i = 1'b0; decay_off_i = 1'b1;
        if (((LINES - 1) / p) >= c)
          read_check(LINES - 1, 1'b1, "R6 readmitted line stays granted");
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule